// File: doc/BRIEF.md
# Breakpoint Flag Map

This block keeps one flag bit for each location of the CPU program address space, so that any mix of program addresses can be marked as breakpoints at the same time. Every instruction fetch that the CPU reports through the fetch strobe is looked up in the map. One clock later the block reports whether that address carries a breakpoint. The emulation control logic then uses this indication to divert the CPU into its monitor.

A host command stream, with valid/ready flow control, marks or unmarks single addresses, or erases the whole map. An erase steps through every address, one per clock. While it runs, the block raises a busy pin and holds ready low, so the host must keep its next command waiting. A command transfers on any clock edge where valid and ready are both high. While ready is low, the host must hold valid, opcode and address stable, and the block ignores them. Lookups are blocked while the CPU is running the monitor, so monitor code never trips a break.

Top module: `brk_flag_map`

## Requirements
- R1: After reset, brk_hit and wipe_busy are 0, cmd_ready is 1, and a fetch of any address reports no break.
- R2: An accepted command with cmd_op = 2'b01 sets the flag at cmd_addr. A later fetch of that address drives brk_hit to 1 on the clock after the strobe.
- R3: An accepted command with cmd_op = 2'b10 clears the flag at cmd_addr. A later fetch of that address gives brk_hit = 0.
- R4: brk_hit is 1 only in the cycle that follows a cycle with fetch_stb high. Without a strobe it is 0, even when the addressed flag is set.
- R5: Flags at any number of addresses can be set together, including address 0 and the top address. Each one breaks independently.
- R6: A fetch made while monitor_mode is 1 gives brk_hit = 0, whatever the flag is.
- R7: When a command write and a fetch of the same address fall in the same cycle, the lookup returns the flag value from before the write. The new value is seen from the next fetch on.
- R8: An accepted command with cmd_op = 2'b11 raises wipe_busy from the next cycle for exactly 2^ADDR_W cycles. Afterwards every flag is 0.
- R9: While wipe_busy is 1, cmd_ready is 0 and offered commands have no effect on the map.
- R10: An accepted command with cmd_op = 2'b00 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Host command offered |
| cmd_ready | output | 1 | Block can take a command (low during erase) |
| cmd_op | input | 2 | 00 none, 01 set, 10 clear, 11 erase all |
| cmd_addr | input | ADDR_W | Target program address for set/clear |
| fetch_stb | input | 1 | CPU instruction fetch strobe |
| fetch_addr | input | ADDR_W | Fetch program address |
| monitor_mode | input | 1 | CPU is running the monitor; blocks lookups |
| brk_hit | output | 1 | Fetch address of previous cycle is a breakpoint |
| wipe_busy | output | 1 | Erase walk in progress |

## Verification
A flag write takes effect on the edge that accepts its command. brk_hit is due one edge after the strobe. So the bench drives on falling edges and samples each result at the falling edge that follows the capture edge. For the erase, the bench counts the falling edges that see wipe_busy high and expects exactly 2^ADDR_W of them. It then makes lookups at both ends of the address range. The same-cycle case drives a command and a fetch on one falling edge and expects the old flag value. A second fetch afterwards must show the new value.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_SET  = 2'b01,
    OP_CLR  = 2'b10,
    OP_WIPE = 2'b11
  } brk_op_e;
endpackage

// File: rtl/brk_wipe_seq.sv
module brk_wipe_seq #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              we,
  output logic [ADDR_W-1:0] waddr
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic [ADDR_W-1:0] ptr_q;
  logic              busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else if (busy_q) begin
      if (ptr_q == LAST) begin
        busy_q <= 1'b0;
        ptr_q  <= '0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end else if (start) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end
  end

  assign busy  = busy_q;
  assign we    = busy_q;
  assign waddr = ptr_q;
endmodule

// File: rtl/brk_wr_sel.sv
module brk_wr_sel #(
  parameter int ADDR_W = 10
) (
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_val,
  input  logic              wipe_we,
  input  logic [ADDR_W-1:0] wipe_addr,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic              val
);
  always_comb begin
    if (wipe_we) begin
      we   = 1'b1;
      addr = wipe_addr;
      val  = 1'b0;
    end else begin
      we   = host_we;
      addr = host_addr;
      val  = host_val;
    end
  end
endmodule

// File: rtl/brk_bit_store.sv
module brk_bit_store #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wval,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rd_flag
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] bits_q;
  logic             rd_q;

  // Read samples the pre-write contents on the shared edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      if (we) bits_q[waddr] <= wval;
      rd_q <= re & bits_q[raddr];
    end
  end

  assign rd_flag = rd_q;
endmodule

// File: rtl/brk_flag_map.sv
module brk_flag_map
  import brk_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              fetch_stb,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              monitor_mode,
  output logic              brk_hit,
  output logic              wipe_busy
);
  brk_op_e           op;
  logic              accept;
  logic              host_we;
  logic              wipe_start;
  logic              wipe_we;
  logic [ADDR_W-1:0] wipe_addr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_val;
  logic              lookup;

  assign op         = brk_op_e'(cmd_op);
  assign cmd_ready  = ~wipe_busy;
  assign accept     = cmd_valid & cmd_ready;
  assign host_we    = accept & ((op == OP_SET) | (op == OP_CLR));
  assign wipe_start = accept & (op == OP_WIPE);
  assign lookup     = fetch_stb & ~monitor_mode;

  brk_wipe_seq #(.ADDR_W(ADDR_W)) u_wipe (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wipe_start),
    .busy  (wipe_busy),
    .we    (wipe_we),
    .waddr (wipe_addr)
  );

  brk_wr_sel #(.ADDR_W(ADDR_W)) u_sel (
    .host_we   (host_we),
    .host_addr (cmd_addr),
    .host_val  (op == OP_SET),
    .wipe_we   (wipe_we),
    .wipe_addr (wipe_addr),
    .we        (mem_we),
    .addr      (mem_addr),
    .val       (mem_val)
  );

  brk_bit_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mem_we),
    .waddr   (mem_addr),
    .wval    (mem_val),
    .re      (lookup),
    .raddr   (fetch_addr),
    .rd_flag (brk_hit)
  );
endmodule

// File: rtl/brk_flag_map_chk.sv
module brk_flag_map_chk #(
  parameter int ADDR_W = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       fetch_stb,
  input logic       monitor_mode,
  input logic       brk_hit,
  input logic       wipe_busy
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_cnt <= '0;
    else if (wipe_busy) busy_cnt <= busy_cnt + 1'b1;
    else                busy_cnt <= '0;
  end

  AST_HIT_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_stb |=> !brk_hit); // R4
  AST_MONITOR_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stb && monitor_mode) |=> !brk_hit); // R6
  AST_WIPE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'b11) |=> wipe_busy); // R8
  AST_WIPE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= (ADDR_W+1)'(DEPTH)); // R8
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_busy |-> !cmd_ready); // R9
endmodule

bind brk_flag_map brk_flag_map_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_op       (cmd_op),
  .fetch_stb    (fetch_stb),
  .monitor_mode (monitor_mode),
  .brk_hit      (brk_hit),
  .wipe_busy    (wipe_busy)
);

// File: tb/tb_brk_flag_map.sv
module tb_brk_flag_map;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] TOP = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic fetch_stb = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic monitor_mode = 1'b0;
  logic brk_hit;
  logic wipe_busy;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  brk_flag_map #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .fetch_stb(fetch_stb),
    .fetch_addr(fetch_addr), .monitor_mode(monitor_mode),
    .brk_hit(brk_hit), .wipe_busy(wipe_busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [AW-1:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic fetch(input logic [AW-1:0] a, input logic mon, output logic hit);
    @(negedge clk);
    fetch_stb = 1'b1; fetch_addr = a; monitor_mode = mon;
    @(negedge clk);
    fetch_stb = 1'b0; monitor_mode = 1'b0;
    hit = brk_hit;
  endtask

  // entry: {is_fetch, op[1:0], mon, exp, req[3:0], addr[AW-1:0]}
  localparam int VW = 9 + AW;
  localparam int NV = 13;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 2'b00, 1'b0, 1'b0, 4'd1,  10'd5},    // R1 empty map
    {1'b0, 2'b01, 1'b0, 1'b0, 4'd2,  10'd5},    // R2 set 5
    {1'b1, 2'b00, 1'b0, 1'b1, 4'd2,  10'd5},    // R2 hit
    {1'b1, 2'b00, 1'b0, 1'b0, 4'd2,  10'd6},    // R2 neighbour unset
    {1'b0, 2'b01, 1'b0, 1'b0, 4'd5,  10'd0},    // R5 set 0
    {1'b0, 2'b01, 1'b0, 1'b0, 4'd5,  10'd1023}, // R5 set top
    {1'b1, 2'b00, 1'b0, 1'b1, 4'd5,  10'd0},    // R5
    {1'b1, 2'b00, 1'b0, 1'b1, 4'd5,  10'd1023}, // R5
    {1'b1, 2'b00, 1'b1, 1'b0, 4'd6,  10'd5},    // R6 monitor blocks
    {1'b0, 2'b10, 1'b0, 1'b0, 4'd3,  10'd5},    // R3 clear 5
    {1'b1, 2'b00, 1'b0, 1'b0, 4'd3,  10'd5},    // R3
    {1'b0, 2'b00, 1'b0, 1'b0, 4'd10, 10'd0},    // R10 no-op on 0
    {1'b1, 2'b00, 1'b0, 1'b1, 4'd10, 10'd0}     // R10 flag kept
  };

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic hit;
    int busy_cycles;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 brk_hit", brk_hit, 0);
    check("R1 wipe_busy", wipe_busy, 0);
    check("R1 cmd_ready", cmd_ready, 1);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      if (v[VW-1]) begin
        fetch(v[AW-1:0], v[VW-4], hit);
        check($sformatf("R%0d vec%0d", v[AW+3:AW], i), hit, v[VW-5]);
      end else begin
        cmd(v[VW-2:VW-3], v[AW-1:0]);
      end
    end

    // R4: no strobe, flag at 0 is set
    @(negedge clk);
    fetch_addr = 10'd0; fetch_stb = 1'b0;
    @(negedge clk);
    check("R4 no strobe", brk_hit, 0);

    // R7: set and fetch same cycle, then clear and fetch same cycle
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 10'd7;
    fetch_stb = 1'b1; fetch_addr = 10'd7;
    @(negedge clk);
    cmd_valid = 1'b0; fetch_stb = 1'b0;
    check("R7 set old value", brk_hit, 0);
    fetch(10'd7, 1'b0, hit);
    check("R7 set new value", hit, 1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_addr = 10'd7;
    fetch_stb = 1'b1; fetch_addr = 10'd7;
    @(negedge clk);
    cmd_valid = 1'b0; fetch_stb = 1'b0;
    check("R7 clear old value", brk_hit, 1);
    fetch(10'd7, 1'b0, hit);
    check("R7 clear new value", hit, 0);

    // R8/R9: erase all, probe ready and blocked command during the walk
    cmd(2'b01, 10'd9);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b11; cmd_addr = '0;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    busy_cycles = 0;
    while (wipe_busy && busy_cycles < DEPTH + 10) begin
      busy_cycles++;
      if (busy_cycles == 2) check("R9 ready low", cmd_ready, 0);
      if (busy_cycles == DEPTH - 3) begin
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 10'd20;
      end
      if (busy_cycles == DEPTH - 1) begin
        cmd_valid = 1'b0; cmd_op = 2'b00;
      end
      @(negedge clk);
    end
    check("R8 busy length", busy_cycles, DEPTH);
    check("R8 ready back", cmd_ready, 1);
    fetch(10'd0, 1'b0, hit);   check("R8 addr 0 erased", hit, 0);
    fetch(TOP, 1'b0, hit);     check("R8 top erased", hit, 0);
    fetch(10'd9, 1'b0, hit);   check("R8 addr 9 erased", hit, 0);
    fetch(10'd20, 1'b0, hit);  check("R9 blocked set ignored", hit, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule